// File: doc/BRIEF.md
# Mode-Banked Shadow Register File

This block is an integer register file of 32 architectural registers with two combinational read ports and one synchronous write port. Alongside the main array it keeps a small bank of shadow registers. While the privileged-mode input is high, a fixed, non-contiguous group of register numbers is steered to the shadow bank in place of the main array, for both reads and writes. A handler running in privileged mode therefore gets private scratch registers without saving the ones used by ordinary code.

Register numbers 8 to 14 map to shadow slots 0 to 6, and register 25 maps to slot 7. Every other number, and every number while the mode input is low, goes to the main array. The highest register number reads as zero and ignores writes. The mode input is sampled on each cycle and is not stored. The steering logic, the array and the shadow bank are separate submodules. Data width and register count are parameters, and the redirect map is computed from parameters.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every main and shadow entry reads as zero on both read ports, in both modes.
- R2: With `priv_mode` low, a write to register n (0..30) with `wr_en` high is visible on both read ports from the next cycle when they address register n.
- R3: With `priv_mode` high, register numbers 8..14 read and write shadow slots 0..6, and those writes leave the main-array values of registers 8..14 unchanged when read back with `priv_mode` low.
- R4: With `priv_mode` high, register number 25 reads and writes shadow slot 7, and the main-array register 25 is unchanged.
- R5: With `priv_mode` high, register numbers outside {8..14, 25} access the main array, so their values are the same in both modes.
- R6: A value written to a shadow slot is not visible with `priv_mode` low. A value written to a main register that has a shadow is not visible at that number with `priv_mode` high.
- R7: Register 31 always reads zero, and writes to it are discarded.
- R8: A read of the location being written in the same cycle returns the old value. The new value appears one cycle later.
- R9: The two read ports resolve their addresses independently and can return different entries in the same cycle.
- R10: With `wr_en` low, no entry changes, whatever the values of `wr_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries |
| priv_mode | input | 1 | Privileged-mode flag that enables the shadow redirect |
| rd_addr_a | input | 5 | Read port A register number |
| rd_addr_b | input | 5 | Read port B register number |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 64 | Write data |
| rd_data_a | output | 64 | Read port A data |
| rd_data_b | output | 64 | Read port B data |

## Verification
The bench uses the default parameters: 64-bit data, 32 registers and an 8-slot shadow bank whose first seven slots cover registers 8 to 14 and whose last slot covers register 25. These defaults put the contiguous part of the map, the single detached slot, the zero register and the unmapped neighbours 7, 15, 24 and 26 all within reach. Each location gets a distinct pattern in both modes, so a swapped slot or a missed boundary shows up as a wrong value.

// File: rtl/brf_pkg.sv
package brf_pkg;
   // Lookup result for one register number
   typedef struct packed {
      logic       to_shadow;
      logic [2:0] slot;
      logic       is_zero;
   } brf_route_t;
endpackage

// File: rtl/brf_route.sv
module brf_route #(
   parameter int ADDR_W      = 5,
   parameter int RUN_BASE    = 8,
   parameter int RUN_LEN     = 7,
   parameter int EXTRA_REG   = 25,
   parameter int ZERO_REG    = 31
) (
   input  logic              priv_mode,
   input  logic [ADDR_W-1:0] addr,
   output brf_pkg::brf_route_t route
);
   localparam int RUN_LAST = RUN_BASE + RUN_LEN - 1;

   initial begin
      assert (RUN_LEN + 1 <= 8) else $error("shadow bank exceeds slot field");
      assert (EXTRA_REG < RUN_BASE || EXTRA_REG > RUN_LAST) else $error("extra reg overlaps run");
   end

   always_comb begin
      route.to_shadow = 1'b0;
      route.slot      = '0;
      route.is_zero   = (int'(addr) == ZERO_REG);
      if (priv_mode) begin
         if (int'(addr) >= RUN_BASE && int'(addr) <= RUN_LAST) begin
            route.to_shadow = 1'b1;
            route.slot      = 3'(int'(addr) - RUN_BASE);
         end else if (int'(addr) == EXTRA_REG) begin
            route.to_shadow = 1'b1;
            route.slot      = 3'(RUN_LEN);
         end
      end
   end
endmodule

// File: rtl/brf_bank.sv
module brf_bank #(
   parameter int DATA_W  = 64,
   parameter int DEPTH   = 32,
   parameter int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx_a,
   input  logic [IDX_W-1:0]  ridx_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                              mem[g] <= '0;
         else if (we && int'(widx) == g)          mem[g] <= wdata;
      end
   end

   assign rdata_a = mem[ridx_a];
   assign rdata_b = mem[ridx_b];

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem[0]));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
   parameter int DATA_W    = 64,
   parameter int NREGS     = 32,
   parameter int RUN_BASE  = 8,
   parameter int RUN_LEN   = 7,
   parameter int EXTRA_REG = 25,
   parameter int ADDR_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_mode,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b
);
   import brf_pkg::*;
   localparam int ZERO_REG = NREGS - 1;
   localparam int NSHAD    = RUN_LEN + 1;
   localparam int SIDX_W   = $clog2(NSHAD);

   brf_route_t rt_a, rt_b, rt_w;
   logic [DATA_W-1:0] m_a, m_b, s_a, s_b;

   brf_route #(.ADDR_W(ADDR_W), .RUN_BASE(RUN_BASE), .RUN_LEN(RUN_LEN),
               .EXTRA_REG(EXTRA_REG), .ZERO_REG(ZERO_REG))
      u_rt_a (.priv_mode(priv_mode), .addr(rd_addr_a), .route(rt_a));
   brf_route #(.ADDR_W(ADDR_W), .RUN_BASE(RUN_BASE), .RUN_LEN(RUN_LEN),
               .EXTRA_REG(EXTRA_REG), .ZERO_REG(ZERO_REG))
      u_rt_b (.priv_mode(priv_mode), .addr(rd_addr_b), .route(rt_b));
   brf_route #(.ADDR_W(ADDR_W), .RUN_BASE(RUN_BASE), .RUN_LEN(RUN_LEN),
               .EXTRA_REG(EXTRA_REG), .ZERO_REG(ZERO_REG))
      u_rt_w (.priv_mode(priv_mode), .addr(wr_addr), .route(rt_w));

   logic main_we, shad_we;
   assign main_we = wr_en && !rt_w.to_shadow && !rt_w.is_zero;
   assign shad_we = wr_en &&  rt_w.to_shadow;

   brf_bank #(.DATA_W(DATA_W), .DEPTH(NREGS)) u_main (
      .clk(clk), .rst_n(rst_n), .we(main_we), .widx(wr_addr), .wdata(wr_data),
      .ridx_a(rd_addr_a), .ridx_b(rd_addr_b), .rdata_a(m_a), .rdata_b(m_b));

   brf_bank #(.DATA_W(DATA_W), .DEPTH(NSHAD)) u_shad (
      .clk(clk), .rst_n(rst_n), .we(shad_we), .widx(rt_w.slot[SIDX_W-1:0]),
      .wdata(wr_data), .ridx_a(rt_a.slot[SIDX_W-1:0]),
      .ridx_b(rt_b.slot[SIDX_W-1:0]), .rdata_a(s_a), .rdata_b(s_b));

   always_comb begin
      rd_data_a = rt_a.is_zero ? '0 : (rt_a.to_shadow ? s_a : m_a);
      rd_data_b = rt_b.is_zero ? '0 : (rt_b.to_shadow ? s_b : m_b);
   end

   initial begin
      assert (NREGS == 2**ADDR_W) else $error("NREGS must fill address space");
      assert (EXTRA_REG < ZERO_REG) else $error("extra reg collides with zero reg");
   end

   // R7
   zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr_a) == ZERO_REG) |-> (rd_data_a == '0));
   // R7
   zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr_b) == ZERO_REG) |-> (rd_data_b == '0));
   // R3
   one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(main_we && shad_we));
   // R5
   no_shadow_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !priv_mode |-> !shad_we);
   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !priv_mode && int'(wr_addr) != ZERO_REG) ##1
      (!priv_mode && rd_addr_a == $past(wr_addr))
      |-> rd_data_a == $past(wr_data));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
   logic clk = 0, rst_n = 0, priv = 0, we = 0;
   logic [4:0] ra = 0, rb = 0, wa = 0;
   logic [63:0] wd = 0, qa, qb;
   int nvec = 0, nbad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   banked_regfile u0 (.clk(clk), .rst_n(rst_n), .priv_mode(priv),
      .rd_addr_a(ra), .rd_addr_b(rb), .wr_en(we), .wr_addr(wa), .wr_data(wd),
      .rd_data_a(qa), .rd_data_b(qb));

   function automatic logic [63:0] pat(int r, bit p);
      return {32'hC0DE_0000 | 32'(r), p ? 32'h5A5A_0001 : 32'h1234_0000};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int r, bit p, logic [63:0] d);
      @(negedge clk); priv = p; we = 1; wa = 5'(r); wd = d;
      @(negedge clk); we = 0;
   endtask

   task automatic rd(int r1, int r2, bit p);
      priv = p; ra = 5'(r1); rb = 5'(r2); #1;
   endtask

   task automatic t_reset;   // R1
      for (int r = 0; r < 32; r++) begin
         rd(r, r, 0); chk("R1", qa, 0); chk("R1", qb, 0);
         rd(r, r, 1); chk("R1", qa, 0);
      end
   endtask

   task automatic t_user;    // R2, R9
      for (int r = 0; r < 31; r++) wr(r, 0, pat(r, 0));
      for (int r = 0; r < 31; r++) begin
         rd(r, 30 - r, 0); chk("R2", qa, pat(r, 0)); chk("R9", qb, pat(30 - r, 0));
      end
   endtask

   task automatic t_shadow;  // R3, R4, R5, R6
      for (int r = 8; r <= 14; r++) wr(r, 1, pat(r, 1));
      wr(25, 1, pat(25, 1));
      for (int r = 8; r <= 14; r++) begin
         rd(r, r, 1); chk("R3", qa, pat(r, 1));
         rd(r, r, 0); chk("R3", qa, pat(r, 0)); chk("R6", qb, pat(r, 0));
      end
      rd(25, 25, 1); chk("R4", qa, pat(25, 1));
      rd(25, 25, 0); chk("R4", qa, pat(25, 0));
      rd(7, 15, 1); chk("R5", qa, pat(7, 0)); chk("R5", qb, pat(15, 0));
      rd(24, 26, 1); chk("R5", qa, pat(24, 0)); chk("R5", qb, pat(26, 0));
      wr(26, 1, 64'hFEED);
      rd(26, 26, 0); chk("R5", qa, 64'hFEED);
      wr(9, 0, 64'hABCD);
      rd(9, 8, 1); chk("R6", qa, pat(9, 1)); chk("R9", qb, pat(8, 1));
      rd(9, 25, 0); chk("R6", qa, 64'hABCD); chk("R9", qb, pat(25, 0));
   endtask

   task automatic t_zero;    // R7
      wr(31, 0, '1); wr(31, 1, '1);
      rd(31, 31, 0); chk("R7", qa, 0); chk("R7", qb, 0);
      rd(31, 31, 1); chk("R7", qa, 0);
   endtask

   task automatic t_old;     // R8
      @(negedge clk); priv = 1; we = 1; wa = 5'd10; wd = 64'h77; ra = 5'd10; #1;
      chk("R8", qa, pat(10, 1));
      @(negedge clk); we = 0; #1;
      chk("R8", qa, 64'h77);
   endtask

   task automatic t_idle;    // R10
      @(negedge clk); priv = 0; we = 0; wa = 5'd3; wd = 64'hDEAD;
      @(negedge clk); priv = 1; wa = 5'd12;
      @(negedge clk);
      rd(3, 12, 0); chk("R10", qa, pat(3, 0)); chk("R10", qb, pat(12, 0));
      rd(12, 3, 1); chk("R10", qa, pat(12, 1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset; t_user; t_shadow; t_zero; t_old; t_idle;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nvec++; nbad++;
         $display("FAIL watchdog: got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule